// File: doc/BRIEF.md
# Byte-Select External Table-Write Sequencer

This block drives one table-write transaction onto a 16-bit multiplexed address/data external bus. The memory on that bus is word-wide but can write single bytes. The CPU side gives a start request, a 21-bit byte pointer, the 8-bit byte to store and a post-increment flag. The block then runs two instruction cycles of four clock phases each. The first instruction cycle belongs to the opcode fetch, so the block leaves the bus alone during it. The write happens in the second instruction cycle.

In the write cycle, the word address goes out on the AD lines during the first phase, and the address-latch strobe is high at the same time. The top address nibble stays on its own lines for the whole cycle. From the second phase on, the data byte is copied onto both halves of AD. Only the high write strobe is used, and it pulses in the third phase. The pointer's lowest bit picks the target byte in two forms: as a byte-address line for flash parts, and as active-low upper/lower byte enables for static RAM. When the transaction ends, a one-clock done pulse is raised and the updated pointer is returned.

Top module: `bsel_wr_seq`

## Requirements
- R1: In write phases Q2, Q3 and Q4 the block drives AD (ad_oe_o=1), and AD equals the latched data byte on both bits 15:8 and 7:0.
- R2: wrh_n_o goes low only in phase Q3 of the write cycle, for exactly one clock per transaction. wrl_n_o stays high at all times.
- R3: During the write cycle ba0_o equals pointer bit 0. lb_n_o is low when that bit is 0 and ub_n_o is low when it is 1, and never both at once. When no write cycle is active, ba0_o=0 and both enables are high.
- R4: In write phase Q1, ale_o=1 and AD carries pointer bits 16:1. ale_o is low in every other clock. addr_hi_o carries pointer bits 20:17 throughout the write cycle and is 0 otherwise.
- R5: During the four clocks after a start is accepted (the fetch instruction cycle) AD is released and ale_o=0. The write phase Q1 follows immediately after them.
- R6: With postinc_i=1 at start, ptr_o equals the start pointer plus one, wrapping modulo 2^21. With postinc_i=0, ptr_o equals the start pointer.
- R7: oe_n_o is always high. AD is released (ad_oe_o=0) whenever no write cycle is active.
- R8: A start request that arrives while a transaction is in progress is ignored. It does not change the address, the data or the returned pointer, and it starts no further bus cycle.
- R9: done_o is high for exactly one clock, the clock after write phase Q4. ptr_o is valid from that clock on.
- R10: After reset, done_o=0, ptr_o=0, ale_o=0, ad_oe_o=0, and all strobes and byte enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one edge per Q phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a table write |
| ptr_i | input | 21 | Byte pointer for the write |
| latch_i | input | 8 | Byte to store |
| postinc_i | input | 1 | Advance the pointer after the write |
| ad_o | output | 16 | Multiplexed address/data value |
| ad_oe_o | output | 1 | High while the block drives AD |
| addr_hi_o | output | 4 | Upper address lines 19:16 |
| ale_o | output | 1 | Address latch strobe, active high |
| oe_n_o | output | 1 | Output enable, active low (held inactive) |
| wrh_n_o | output | 1 | High write strobe, active low |
| wrl_n_o | output | 1 | Low write strobe, active low (unused, held high) |
| ba0_o | output | 1 | Byte address bit for flash devices |
| ub_n_o | output | 1 | Upper byte enable, active low |
| lb_n_o | output | 1 | Lower byte enable, active low |
| done_o | output | 1 | One-clock completion pulse |
| ptr_o | output | 21 | Pointer after the transaction |

## Verification
The bench targets odd and even pointers at the extremes of the range, including the all-ones pointer. A post-increment that did not wrap would return 2^21 there, and a swapped byte select would enable the wrong half of the memory word. The bench holds a start request high during the write cycle. A design that accepted it would overwrite the latched address or run a second ALE pulse. The bench also checks that the fetch slot leaves the bus released. A sequencer that wrote in the first instruction cycle would show ALE four clocks too early. Finally it feeds the returned pointer into the next start, which catches byte selects that do not alternate across post-incremented writes.

// File: rtl/bsel_wr_seq.sv
module bsel_wr_seq #(
  parameter int PTR_W = 21,
  parameter int DAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [DAT_W-1:0] latch_i,
  input  logic             postinc_i,
  output logic [2*DAT_W-1:0] ad_o,
  output logic             ad_oe_o,
  output logic [PTR_W-2*DAT_W-2:0] addr_hi_o,
  output logic             ale_o,
  output logic             oe_n_o,
  output logic             wrh_n_o,
  output logic             wrl_n_o,
  output logic             ba0_o,
  output logic             ub_n_o,
  output logic             lb_n_o,
  output logic             done_o,
  output logic [PTR_W-1:0] ptr_o
);
  localparam int AD_W = 2 * DAT_W;
  localparam int HI_W = PTR_W - AD_W - 1;

  logic             busy_q, wcyc_q, inc_q, done_q;
  logic [1:0]       ph_q;
  logic [PTR_W-1:0] ptr_q, ptr_out_q;
  logic [DAT_W-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      wcyc_q    <= 1'b0;
      inc_q     <= 1'b0;
      done_q    <= 1'b0;
      ph_q      <= 2'd0;
      ptr_q     <= '0;
      ptr_out_q <= '0;
      lat_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          wcyc_q <= 1'b0;
          ph_q   <= 2'd0;
          ptr_q  <= ptr_i;
          lat_q  <= latch_i;
          inc_q  <= postinc_i;
        end
      end else begin
        ph_q <= ph_q + 2'd1;
        if (ph_q == 2'd3) begin
          if (!wcyc_q) begin
            wcyc_q <= 1'b1;
          end else begin
            busy_q    <= 1'b0;
            done_q    <= 1'b1;
            ptr_out_q <= ptr_q + PTR_W'(inc_q);
          end
        end
      end
    end
  end

  logic wr_act, in_q1;
  assign wr_act = busy_q & wcyc_q;
  assign in_q1  = wr_act & (ph_q == 2'd0);

  assign ad_oe_o   = wr_act;
  assign ad_o      = !wr_act ? '0 : in_q1 ? ptr_q[AD_W:1] : {lat_q, lat_q};
  assign addr_hi_o = wr_act ? ptr_q[PTR_W-1 -: HI_W] : '0;
  assign ale_o     = in_q1;
  assign oe_n_o    = 1'b1;
  assign wrh_n_o   = !(wr_act && ph_q == 2'd2);
  assign wrl_n_o   = 1'b1;
  assign ba0_o     = wr_act & ptr_q[0];
  assign ub_n_o    = !(wr_act && ptr_q[0]);
  assign lb_n_o    = !(wr_act && !ptr_q[0]);
  assign done_o    = done_q;
  assign ptr_o     = ptr_out_q;

  assert_one_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wrh_n_o |-> (ub_n_o != lb_n_o));
  assert_dual_copy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wrh_n_o |-> (ad_oe_o && ad_o[AD_W-1:DAT_W] == ad_o[DAT_W-1:0]));
  assert_wrh_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wrh_n_o) |=> wrh_n_o);
  assert_ale_then_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> (ad_oe_o && !ale_o));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !ad_oe_o);
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !(wcyc_q && ph_q == 2'd3)) |=> ($stable(lat_q) && $stable(ptr_q) && busy_q));
endmodule

// File: tb/bsel_wr_seq_test.sv
module bsel_wr_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [20:0] ptr_i = '0;
  logic [7:0]  latch_i = '0;
  logic        postinc_i = 1'b0;
  logic [15:0] ad_o;
  logic        ad_oe_o;
  logic [3:0]  addr_hi_o;
  logic        ale_o, oe_n_o, wrh_n_o, wrl_n_o, ba0_o, ub_n_o, lb_n_o, done_o;
  logic [20:0] ptr_o;

  bsel_wr_seq uut (.clk(clk), .rst_n(rst_n), .start_i(start_i), .ptr_i(ptr_i),
    .latch_i(latch_i), .postinc_i(postinc_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .addr_hi_o(addr_hi_o), .ale_o(ale_o), .oe_n_o(oe_n_o), .wrh_n_o(wrh_n_o),
    .wrl_n_o(wrl_n_o), .ba0_o(ba0_o), .ub_n_o(ub_n_o), .lb_n_o(lb_n_o),
    .done_o(done_o), .ptr_o(ptr_o));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ptr, data, postinc, addr_hi, ad address, ba0, ptr after
  typedef struct packed {
    logic [20:0] ptr; logic [7:0] dat; logic pinc;
    logic [3:0] hi; logic [15:0] adr; logic b0; logic [20:0] pout;
  } vec_t;
  localparam vec_t VECS [5] = '{
    '{21'h000000, 8'h5A, 1'b1, 4'h0, 16'h0000, 1'b0, 21'h000001},
    '{21'h000001, 8'hC3, 1'b0, 4'h0, 16'h0000, 1'b1, 21'h000001},
    '{21'h1FFFFF, 8'hFF, 1'b1, 4'hF, 16'hFFFF, 1'b1, 21'h000000},
    '{21'h0E2468, 8'h00, 1'b0, 4'h7, 16'h1234, 1'b0, 21'h0E2468},
    '{21'h13579B, 8'hA5, 1'b1, 4'h9, 16'hABCD, 1'b1, 21'h13579C}
  };

  task automatic run_write(input vec_t v, input bit poke_busy);
    @(negedge clk);
    start_i = 1'b1; ptr_i = v.ptr; latch_i = v.dat; postinc_i = v.pinc;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (i > 0) @(negedge clk);
      chk("R5 fetch slot released", {ad_oe_o, ale_o, wrh_n_o}, 3'b001);
    end
    @(negedge clk);
    chk("R4 Q1 ale", ale_o, 1'b1);
    chk("R4 Q1 address", ad_o, v.adr);
    chk("R4 addr hi", addr_hi_o, v.hi);
    chk("R2 Q1 wrh idle", wrh_n_o, 1'b1);
    @(negedge clk);
    if (poke_busy) begin start_i = 1'b1; ptr_i = ~v.ptr; latch_i = ~v.dat; postinc_i = ~v.pinc; end
    chk("R1 Q2 data", {ad_oe_o, ad_o}, {1'b1, v.dat, v.dat});
    chk("R4 ale low Q2", ale_o, 1'b0);
    @(negedge clk);
    chk("R2 Q3 strobe", {wrh_n_o, wrl_n_o, oe_n_o}, 3'b011);
    chk("R1 Q3 data", ad_o, {v.dat, v.dat});
    chk("R3 byte select", {ba0_o, ub_n_o, lb_n_o}, {v.b0, !v.b0, v.b0});
    chk("R4 addr hi Q3", addr_hi_o, v.hi);
    @(negedge clk);
    if (poke_busy) start_i = 1'b0;
    chk("R2 Q4 strobe off", wrh_n_o, 1'b1);
    chk("R1 Q4 data", {ad_oe_o, ad_o}, {1'b1, v.dat, v.dat});
    chk("R9 no early done", done_o, 1'b0);
    @(negedge clk);
    chk("R9 done", done_o, 1'b1);
    chk("R6 ptr out", ptr_o, v.pout);
    chk("R7 released after", {ad_oe_o, oe_n_o, ub_n_o, lb_n_o, ba0_o}, 5'b01110);
    @(negedge clk);
    chk("R9 done single", done_o, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", {done_o, ale_o, ad_oe_o, wrh_n_o, wrl_n_o, oe_n_o, ub_n_o, lb_n_o}, 8'b00011111);
    chk("R10 reset ptr", ptr_o, 21'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 idle released", {ad_oe_o, oe_n_o}, 2'b01);

    foreach (VECS[k]) run_write(VECS[k], 1'b0);

    // R8: start held during the write cycle is ignored
    run_write('{21'h0402A6, 8'h3C, 1'b1, 4'h2, 16'h0153, 1'b0, 21'h0402A7}, 1'b1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R8 no extra cycle", {ale_o, ad_oe_o, done_o}, 3'b000);
    end

    // R6 chain: returned pointer feeds next write, byte selects alternate
    run_write('{21'h00A010, 8'h11, 1'b1, 4'h0, 16'h5008, 1'b0, 21'h00A011}, 1'b0);
    run_write('{ptr_o, 8'h22, 1'b1, 4'h0, 16'h5008, 1'b1, 21'h00A012}, 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule